// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Keyed Write Protection

This block is a register-mapped watchdog. Its countdown runs as two chained stages. The first stage counts down its preload and, on expiry, can raise a level interrupt. The second stage then counts down its own preload. On expiry it emits a one-cycle reset request and sets a sticky timed-out flag. A prescaler turns the bus clock into the count tick. The tick is either a slow rate of the clock divided by 2^15, or a fast rate of the clock divided by 2^5 for short runs.

The timing registers are guarded. These are the two preloads and the reload/flag register. Software opens them by writing the key byte 0x80 and then 0x86 into the low byte of the reload register. Exactly one protected write is then accepted, and the gate closes again. The configuration and control registers are not guarded. Instead, the control register has a sticky lock bit, and once it is set the enable and lock bits can no longer be cleared until reset. The register bus is a plain single-cycle write port with byte strobes and a combinational read port. It has no back-pressure: every write completes in the cycle it is presented.

Top module: `dual_stage_wdog`

## Requirements
- R1: After reset, both outputs are low and counting is off. Both preloads read back 15360 (30 << 9). The control register (offset 0x14) reads 0, and the reload register (0x0C) reads 0.
- R2: Writing 0x80 and then 0x86 into byte 0 of the reload register (0x0C) permits exactly one write to a protected register: preload one at 0x00, preload two at 0x04, or reload at 0x0C. A second protected write after that is ignored. Byte strobes select which bytes of a preload are updated.
- R3: A protected write with no fresh key pair is ignored. A wrong second key byte sends the key sequence back to its start.
- R4: With configuration (0x10) bit 2 set, the count tick comes every 32 clock cycles. With bit 2 clear, it comes every 2^15 cycles.
- R5: When stage one expires, status bit 0 at offset 0x08 is set and the interrupt output goes high. This happens unless configuration bits 1:0 equal 11, in which case neither occurs. Writing 1 to status bit 0 clears the status bit and the output, and needs no key.
- R6: A stage expires on the tick after its count reaches zero. With configuration bit 5 clear, the expiry of stage two drives the reset output high for exactly one cycle. On that same edge it sets the flag in reload bit 9. From the enable write, the pulse arrives (P1+P2+2)*32 cycles later at the fast tick.
- R7: With configuration bit 5 set, stage-two expiry gives no reset pulse and leaves the flag clear.
- R8: A keyed write of 1 to reload bit 8 restarts stage one from preload one, leaving the tick phase unchanged. The flag survives a restart, and a keyed write of 1 to bit 9 clears it.
- R9: A restart that lands on the same edge as a stage-two expiry wins: no reset pulse is emitted.
- R10: Control bit 1 enables counting, and clearing it stops all expiries. Once control bit 0 (lock) is set, control writes can only set bits, until reset.
- R11: A preload of zero expires on the next tick.
- R12: With control bit 2 set (free-timer function), stage two expires with no reset pulse, while stage one still raises its status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and count clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 5 | Register byte offset |
| bus_wen_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_strb_i | input | 4 | Byte enables for the write |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Stage-one interrupt level |
| wdt_rst_o | output | 1 | One-cycle reset request on stage-two expiry |

## Verification
A keyed restart command and the expiry of stage two can fall on the same clock edge. The bench provokes this case. It first measures the fixed pulse period from an observed reset pulse. It then times the key pair and the restart so that the restart is captured exactly on the edge where the next expiry is due. The result passes when no pulse appears on that edge and the next pulse arrives exactly one full two-stage period after the restart.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_PRE1 = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_PRE2 = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_RELD = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h14;

  localparam logic [7:0] KEY_A = 8'h80;
  localparam logic [7:0] KEY_B = 8'h86;

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} unlock_e;
  typedef enum logic {ST_ONE, ST_TWO} stage_e;
endpackage

// File: rtl/dsw_tick.sv
module dsw_tick #(
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int CW = SLOW_LOG2;
  localparam logic [CW-1:0] FAST_LIM = CW'((1 << FAST_LOG2) - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = fast_i ? FAST_LIM : {CW{1'b1}};
  assign tick_o = run_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/dsw_unlock.sv
module dsw_unlock
  import dsw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_wr_i,
  input  logic [7:0] key_byte_i,
  input  logic       prot_wr_i,
  output logic       grant_o
);
  unlock_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      UL_IDLE: if (key_wr_i && key_byte_i == KEY_A) state_d = UL_HALF;
      UL_HALF: if (key_wr_i) state_d = (key_byte_i == KEY_B) ? UL_OPEN : UL_IDLE;
      UL_OPEN: if (prot_wr_i) state_d = UL_IDLE;
      default: state_d = UL_IDLE;
    endcase
  end

  assign grant_o = (state_q == UL_OPEN) && prot_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= UL_IDLE;
    else         state_q <= state_d;
  end

  // R2
  one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> state_q == UL_IDLE);
  // R3
  key_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == UL_IDLE |=> state_q != UL_OPEN);
endmodule

// File: rtl/dsw_stages.sv
module dsw_stages
  import dsw_pkg::*;
#(
  parameter int PRE_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] pre1_i,
  input  logic [PRE_W-1:0] pre2_i,
  output logic             s1_hit_o,
  output logic             s2_hit_o
);
  logic [PRE_W-1:0] cnt_q;
  stage_e           stg_q;
  logic             fire;

  assign fire     = run_i && tick_i && !restart_i && (cnt_q == '0);
  assign s1_hit_o = fire && (stg_q == ST_ONE);
  assign s2_hit_o = fire && (stg_q == ST_TWO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= ST_ONE;
      cnt_q <= '0;
    end else if (!run_i || restart_i) begin
      stg_q <= ST_ONE;
      cnt_q <= pre1_i;
    end else if (tick_i) begin
      if (cnt_q == '0) begin
        stg_q <= (stg_q == ST_ONE) ? ST_TWO : ST_ONE;
        cnt_q <= (stg_q == ST_ONE) ? pre2_i : pre1_i;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R10
  halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (stg_q == ST_ONE) && (cnt_q == $past(pre1_i)));
  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && restart_i) |=> (stg_q == ST_ONE) && (cnt_q == $past(pre1_i)));
endmodule

// File: rtl/dual_stage_wdog.sv
module dual_stage_wdog
  import dsw_pkg::*;
#(
  parameter int PRE_W     = 20,
  parameter int DFLT_SECS = 30,
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wen_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [3:0]        bus_strb_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  localparam logic [PRE_W-1:0] PRE_RST = PRE_W'(DFLT_SECS << 9);

  logic [PRE_W-1:0] pre1_q, pre2_q;
  logic             reboot_off_q, fast_q, func_q, en_q, lock_q;
  logic [1:0]       itype_q;
  logic             irq_pend_q, flag_q, rst_q;

  logic wr_pre1, wr_pre2, wr_reld, wr_stat, wr_cfg, wr_ctrl;
  logic grant, restart, flag_clr, tick, s1_hit, s2_hit, boom;
  logic [DATA_W-1:0] bmask;

  assign wr_pre1 = bus_wen_i && bus_addr_i == OFS_PRE1;
  assign wr_pre2 = bus_wen_i && bus_addr_i == OFS_PRE2;
  assign wr_reld = bus_wen_i && bus_addr_i == OFS_RELD;
  assign wr_stat = bus_wen_i && bus_addr_i == OFS_STAT && bus_strb_i[0];
  assign wr_cfg  = bus_wen_i && bus_addr_i == OFS_CFG  && bus_strb_i[0];
  assign wr_ctrl = bus_wen_i && bus_addr_i == OFS_CTRL && bus_strb_i[0];

  for (genvar b = 0; b < 4; b++) begin : g_mask
    assign bmask[8*b +: 8] = {8{bus_strb_i[b]}};
  end

  function automatic logic [PRE_W-1:0] merge(input logic [PRE_W-1:0] old);
    logic [DATA_W-1:0] full;
    full  = (DATA_W'(old) & ~bmask) | (bus_wdata_i & bmask);
    return full[PRE_W-1:0];
  endfunction

  dsw_unlock u_unlock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_wr_i   (wr_reld && bus_strb_i[0]),
    .key_byte_i (bus_wdata_i[7:0]),
    .prot_wr_i  (wr_pre1 || wr_pre2 || wr_reld),
    .grant_o    (grant)
  );

  assign restart  = grant && wr_reld && bus_strb_i[1] && bus_wdata_i[8];
  assign flag_clr = grant && wr_reld && bus_strb_i[1] && bus_wdata_i[9];

  dsw_tick #(.SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_q),
    .fast_i (fast_q),
    .tick_o (tick)
  );

  dsw_stages #(.PRE_W(PRE_W)) u_stages (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (en_q),
    .tick_i    (tick),
    .restart_i (restart),
    .pre1_i    (pre1_q),
    .pre2_i    (pre2_q),
    .s1_hit_o  (s1_hit),
    .s2_hit_o  (s2_hit)
  );

  assign boom = s2_hit && !reboot_off_q && !func_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre1_q <= PRE_RST;
      pre2_q <= PRE_RST;
      {reboot_off_q, fast_q, itype_q} <= '0;
      {func_q, en_q, lock_q} <= '0;
      irq_pend_q <= 1'b0;
      flag_q     <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      if (grant && wr_pre1) pre1_q <= merge(pre1_q);
      if (grant && wr_pre2) pre2_q <= merge(pre2_q);
      if (wr_cfg) begin
        reboot_off_q <= bus_wdata_i[5];
        fast_q       <= bus_wdata_i[2];
        itype_q      <= bus_wdata_i[1:0];
      end
      if (wr_ctrl) begin
        if (lock_q) {func_q, en_q, lock_q} <= {func_q, en_q, lock_q} | bus_wdata_i[2:0];
        else        {func_q, en_q, lock_q} <= bus_wdata_i[2:0];
      end
      if (s1_hit && itype_q != 2'b11)  irq_pend_q <= 1'b1;
      else if (wr_stat && bus_wdata_i[0]) irq_pend_q <= 1'b0;
      if (boom)          flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      rst_q <= boom;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFS_PRE1: bus_rdata_o = DATA_W'(pre1_q);
      OFS_PRE2: bus_rdata_o = DATA_W'(pre2_q);
      OFS_STAT: bus_rdata_o[0] = irq_pend_q;
      OFS_RELD: bus_rdata_o[9] = flag_q;
      OFS_CFG:  bus_rdata_o[5:0] = {reboot_off_q, 2'b00, fast_q, itype_q};
      OFS_CTRL: bus_rdata_o[2:0] = {func_q, en_q, lock_q};
      default:  bus_rdata_o = '0;
    endcase
  end

  assign irq_o     = irq_pend_q;
  assign wdt_rst_o = rst_q;

  // R6
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q);
  // R6
  flag_with_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> flag_q);
  // R7
  quiet_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> $past(!reboot_off_q && !func_q));
  // R10
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && en_q) |=> (lock_q && en_q));
  // R5
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_pend_q) |-> $past(itype_q) != 2'b11);
endmodule

// File: tb/dual_stage_wdog_tb_top.sv
module dual_stage_wdog_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wen = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  strb = '0;
  logic [31:0] rdata;
  logic        irq, wrst;

  int n_chk = 0;
  int n_bad = 0;
  localparam int PERIOD = 224; // (2+3+2)*32

  always #2 clk = ~clk;

  dual_stage_wdog dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wen_i(wen),
    .bus_wdata_i(wdata), .bus_strb_i(strb), .bus_rdata_o(rdata),
    .irq_o(irq), .wdt_rst_o(wrst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    addr = a; wdata = d; strb = s; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic keys();
    wr(5'h0C, 32'h80, 4'b0001);
    wr(5'h0C, 32'h86, 4'b0001);
  endtask

  task automatic pwr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    keys();
    wr(a, d, s);
  endtask

  task automatic wait_rst(output int c, input int lim);
    c = 0;
    while (c < lim && !wrst) begin @(negedge clk); c++; end
  endtask

  task automatic count_rst(output int p, input int cycles);
    p = 0;
    for (int i = 0; i < cycles; i++) begin @(negedge clk); if (wrst) p++; end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 rst_o", 32'(wrst), 0);
    chk("R1 irq_o", 32'(irq), 0);
    rd(5'h00, v); chk("R1 pre1", v, 15360);
    rd(5'h04, v); chk("R1 pre2", v, 15360);
    rd(5'h14, v); chk("R1 ctrl", v, 0);
    rd(5'h0C, v); chk("R1 reload", v, 0);
  endtask

  task automatic t_unlock();
    logic [31:0] v;
    wr(5'h00, 5, 4'hF);
    rd(5'h00, v); chk("R3 no key", v, 15360);
    pwr(5'h00, 2, 4'hF);
    rd(5'h00, v); chk("R2 keyed write", v, 2);
    wr(5'h00, 7, 4'hF);
    rd(5'h00, v); chk("R2 single use", v, 2);
    wr(5'h0C, 32'h80, 4'b0001); wr(5'h0C, 32'h55, 4'b0001); wr(5'h0C, 32'h86, 4'b0001);
    wr(5'h04, 9, 4'hF);
    rd(5'h04, v); chk("R3 bad key", v, 15360);
    pwr(5'h04, 32'hFFFF_FFFF, 4'b0001);
    rd(5'h04, v); chk("R2 strobe", v, (15360 & ~32'hFF) | 32'hFF);
    pwr(5'h04, 3, 4'hF);
    rd(5'h04, v); chk("R2 pre2", v, 3);
  endtask

  task automatic t_irq();
    logic [31:0] v; int c;
    wr(5'h10, 32'h04, 4'b0001);
    wr(5'h14, 32'h02, 4'b0001);
    c = 0;
    while (c < 200 && !irq) begin @(negedge clk); c++; end
    chk("R5 irq time", c, 96);
    rd(5'h08, v); chk("R5 status", v, 1);
    wr(5'h08, 1, 4'b0001);
    chk("R5 irq cleared", 32'(irq), 0);
    rd(5'h08, v); chk("R5 status cleared", v, 0);
    wr(5'h14, 0, 4'b0001);
    wr(5'h10, 32'h07, 4'b0001);
    wr(5'h14, 32'h02, 4'b0001);
    repeat (120) @(negedge clk);
    chk("R5 type 11 irq", 32'(irq), 0);
    rd(5'h08, v); chk("R5 type 11 status", v, 0);
    wr(5'h14, 0, 4'b0001);
  endtask

  task automatic t_expire();
    logic [31:0] v; int c;
    wr(5'h10, 32'h04, 4'b0001);
    wr(5'h14, 32'h02, 4'b0001);
    wait_rst(c, 400);
    chk("R6 R4 pulse time", c, PERIOD);
    rd(5'h0C, v); chk("R6 flag set", v, 32'h200);
    @(negedge clk);
    chk("R6 one cycle", 32'(wrst), 0);
  endtask

  task automatic t_collide();
    logic [31:0] v; int c;
    wait_rst(c, 400);
    repeat (PERIOD - 3) @(negedge clk);
    keys();
    wr(5'h0C, 32'h100, 4'b0010);
    chk("R9 restart beats expiry", 32'(wrst), 0);
    wait_rst(c, 400);
    chk("R8 R9 restart period", c, PERIOD);
    rd(5'h0C, v); chk("R8 flag survives", v, 32'h200);
    pwr(5'h0C, 32'h200, 4'b0010);
    rd(5'h0C, v); chk("R8 flag cleared", v, 0);
    wr(5'h14, 0, 4'b0001);
  endtask

  task automatic t_zero();
    int c;
    pwr(5'h00, 0, 4'hF);
    pwr(5'h04, 0, 4'hF);
    wr(5'h14, 32'h02, 4'b0001);
    wait_rst(c, 200);
    chk("R11 zero preload", c, 64);
    wr(5'h14, 0, 4'b0001);
    pwr(5'h0C, 32'h200, 4'b0010);
    wr(5'h08, 1, 4'b0001);
  endtask

  task automatic t_noreboot();
    logic [31:0] v; int p;
    wr(5'h10, 32'h24, 4'b0001);
    wr(5'h14, 32'h02, 4'b0001);
    count_rst(p, 300);
    chk("R7 no pulse", p, 0);
    rd(5'h0C, v); chk("R7 no flag", v, 0);
    wr(5'h14, 0, 4'b0001);
    wr(5'h08, 1, 4'b0001);
    wr(5'h10, 32'h04, 4'b0001);
    wr(5'h14, 32'h06, 4'b0001);
    count_rst(p, 300);
    chk("R12 free timer no pulse", p, 0);
    rd(5'h08, v); chk("R12 stage one runs", v, 1);
    wr(5'h14, 0, 4'b0001);
    wr(5'h08, 1, 4'b0001);
  endtask

  task automatic t_stop();
    int p;
    wr(5'h14, 32'h02, 4'b0001);
    repeat (40) @(negedge clk);
    wr(5'h14, 0, 4'b0001);
    count_rst(p, 300);
    chk("R10 disabled no pulse", p, 0);
  endtask

  task automatic t_lock();
    logic [31:0] v; int c;
    wr(5'h14, 32'h03, 4'b0001);
    wr(5'h14, 0, 4'b0001);
    rd(5'h14, v); chk("R10 locked", v, 3);
    wait_rst(c, 200);
    chk("R10 still counting", 32'(c < 200), 1);
    do_reset();
    rd(5'h14, v); chk("R1 ctrl after reset", v, 0);
    rd(5'h00, v); chk("R1 pre1 after reset", v, 15360);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    summary();
  end

  initial begin
    do_reset();
    t_reset();
    t_unlock();
    t_irq();
    t_expire();
    t_collide();
    t_zero();
    t_noreboot();
    t_stop();
    t_lock();
    summary();
  end
endmodule